// File: doc/BRIEF.md
# Repeated-Subtraction Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor. It subtracts the divisor from a running remainder over and over, and counts how many subtractions succeed. A borrow-chain subtractor computes the difference. The same subtractor's final borrow decides whether one more subtraction is legal, so no separate comparator exists. A three-state Moore controller sequences a small datapath. The datapath holds the quotient counter, the remainder and a captured copy of the divisor.

A client presents the operands and raises `start`. The controller leaves its wait state (`ST_WAIT`). It then either enters the subtraction loop (`ST_LOOP`) or, when the divisor is zero, goes straight to the finished state (`ST_DONE`). The loop stays in `ST_LOOP` while the subtractor reports no borrow. The first borrow moves it to `ST_DONE`, where `done` is high. The controller goes back to `ST_WAIT` once `start` is released. The latency grows with the quotient: a result with quotient q needs q+2 clock edges, counted from the edge that samples `start`. The operand width is set by parameter `W` (default 8).

Transitions: `ST_WAIT`→`ST_LOOP` (start, divisor non-zero), `ST_WAIT`→`ST_DONE` (start, divisor zero), `ST_LOOP`→`ST_LOOP` (no borrow), `ST_LOOP`→`ST_DONE` (borrow), `ST_DONE`→`ST_DONE` (start held), `ST_DONE`→`ST_WAIT` (start low).

Top module: `rsub_divider`

## Requirements
- R1: In the wait state, a high `start` with a non-zero `b_in` sets `q_out` to 0 and `r_out` to `a_in` on the next edge, and the controller enters the loop.
- R2: On each loop cycle in which the remainder is at least the captured divisor, the remainder is reduced by the divisor and the quotient is incremented by one, both on the same edge.
- R3: The loop ends on the first cycle in which the subtractor borrows. The final outputs are then `q_out` = floor(A/B) and `r_out` = A mod B, with `r_out` less than the divisor.
- R4: In the wait state with `start` low, `q_out` and `r_out` hold their values and `done` stays low.
- R5: `done` is high only in the finished state. For a non-zero divisor it rises q+2 edges after the edge that samples `start`.
- R6: While `start` stays high in the finished state, `done`, `q_out` and `r_out` hold. One edge after `start` is low, `done` is low and the controller is back in the wait state.
- R7: A zero divisor gives `done` one edge after `start` is sampled, with `q_out` all ones and `r_out` equal to `a_in`.
- R8: After an asynchronous active-low reset, `q_out` and `r_out` are 0, `done` is 0 and the controller is in the wait state.
- R9: Both operands are captured when `start` is accepted. Changing `a_in` or `b_in` during the loop has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; also acknowledges a finished result when lowered |
| a_in | input | W | Unsigned dividend |
| b_in | input | W | Unsigned divisor |
| q_out | output | W | Quotient |
| r_out | output | W | Remainder |
| done | output | 1 | Result valid (finished state) |

## Verification
The bench aims at the extremes of the loop count:
- A dividend smaller than the divisor exits after a single borrow cycle; a design that tested the borrow one cycle late would return quotient 1.
- A divisor of one runs the longest loop.
- Equal operands expose an off-by-one in the borrow test, which would show remainder B instead of 0.
- A zero divisor would hang a design without the guard, and the watchdog would expire.
- Changing the operands in the middle of the loop, and holding `start` across the finished state, catch a design that reads `b_in` live or drops `done` early.

// File: rtl/rsub_pkg.sv
package rsub_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOOP = 2'd1,
        ST_DONE = 2'd2
    } div_state_t;

endpackage

// File: rtl/rsub_borrow_chain.sv
module rsub_borrow_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff,
    output logic         no_borrow
);
    logic [W:0] bor;

    assign bor[0] = 1'b0;

    // ripple full-subtractor cells; the last borrow doubles as the compare
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic x, y;
        assign x       = minuend[i];
        assign y       = subtrahend[i];
        assign diff[i] = x ^ y ^ bor[i];
        assign bor[i+1] = (~x & y) | (~(x ^ y) & bor[i]);
    end

    assign no_borrow = ~bor[W];

endmodule

// File: rtl/rsub_ctrl.sv
module rsub_ctrl
    import rsub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       divisor_zero,
    input  logic       ge,
    output div_state_t st,
    output logic       load,
    output logic       zload,
    output logic       step,
    output logic       done
);
    div_state_t st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_WAIT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_WAIT: if (start) st_nx = divisor_zero ? ST_DONE : ST_LOOP;
            ST_LOOP: if (!ge)   st_nx = ST_DONE;
            ST_DONE: if (!start) st_nx = ST_WAIT;
            default: st_nx = ST_WAIT;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        zload = 1'b0;
        step  = 1'b0;
        done  = 1'b0;
        unique case (st)
            ST_WAIT: begin
                load  = start & ~divisor_zero;
                zload = start &  divisor_zero;
            end
            ST_LOOP: step = ge;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rsub_datapath.sv
module rsub_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         zload,
    input  logic         step,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] q_reg,
    output logic [W-1:0] r_reg,
    output logic [W-1:0] b_lat,
    output logic         ge
);
    localparam logic [W-1:0] QMAX = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] diff;

    rsub_borrow_chain #(.W(W)) sub_i (
        .minuend   (r_reg),
        .subtrahend(b_lat),
        .diff      (diff),
        .no_borrow (ge)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_reg <= '0;
            r_reg <= '0;
            b_lat <= '0;
        end else if (load) begin
            q_reg <= '0;
            r_reg <= a_in;
            b_lat <= b_in;
        end else if (zload) begin
            q_reg <= QMAX;
            r_reg <= a_in;
            b_lat <= '0;
        end else if (step) begin
            q_reg <= q_reg + ONE;
            r_reg <= diff;
        end
    end

endmodule

// File: rtl/rsub_divider.sv
module rsub_divider
    import rsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out,
    output logic         done
);
    div_state_t   st_w;
    logic         load_w, zload_w, step_w, ge_w, bzero_w;
    logic [W-1:0] b_lat_w;

    assign bzero_w = (b_in == '0);

    rsub_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .divisor_zero(bzero_w),
        .ge          (ge_w),
        .st          (st_w),
        .load        (load_w),
        .zload       (zload_w),
        .step        (step_w),
        .done        (done)
    );

    rsub_datapath #(.W(W)) dp_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_w),
        .zload(zload_w),
        .step (step_w),
        .a_in (a_in),
        .b_in (b_in),
        .q_reg(q_out),
        .r_reg(r_out),
        .b_lat(b_lat_w),
        .ge   (ge_w)
    );

endmodule

// File: rtl/rsub_divider_chk.sv
module rsub_divider_chk
    import rsub_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] q_out,
    input logic [W-1:0] r_out,
    input logic         done,
    input logic [1:0]   st,
    input logic         ge,
    input logic [W-1:0] bl
);
    localparam logic [1:0] S_WAIT = 2'(ST_WAIT);
    localparam logic [1:0] S_LOOP = 2'(ST_LOOP);

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && start && b_in != '0) |=>
            (q_out == '0 && r_out == $past(a_in) && st == S_LOOP));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOOP && ge) |=>
            (q_out == $past(q_out) + 1'b1 && r_out == $past(r_out) - $past(bl)));

    p_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOOP && !ge) |=> (done && r_out < bl));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && !start) |=> ($stable(q_out) && $stable(r_out) && !done));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (done && $stable(q_out) && $stable(r_out)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!done && st == S_WAIT));

    p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && start && b_in == '0) |=>
            (done && q_out == {W{1'b1}} && r_out == $past(a_in)));

endmodule

bind rsub_divider rsub_divider_chk #(.W(W)) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .a_in (a_in),
    .b_in (b_in),
    .q_out(q_out),
    .r_out(r_out),
    .done (done),
    .st   (st_w),
    .ge   (ge_w),
    .bl   (b_lat_w)
);

// File: tb/rsub_divider_tb_top.sv
`timescale 1ns/1ps
module rsub_divider_tb_top;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] q_out, r_out;
    logic         done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rsub_divider #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in),
        .q_out(q_out), .r_out(r_out), .done(done)
    );

    // behavioural reference: 0 idle, 1 dividing, 2 result held
    int m_mode = 0, m_q = 0, m_r = 0, m_b = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0; m_q <= 0; m_r <= 0; m_b <= 0;
        end else begin
            if (m_mode == 0) begin
                if (start) begin
                    if (b_in == 0) begin
                        m_q <= MASK; m_r <= int'(a_in); m_b <= 0; m_mode <= 2;
                    end else begin
                        m_q <= 0; m_r <= int'(a_in); m_b <= int'(b_in); m_mode <= 1;
                    end
                end
            end else if (m_mode == 1) begin
                if (m_r >= m_b) begin
                    m_r <= m_r - m_b; m_q <= m_q + 1;
                end else m_mode <= 2;
            end else begin
                if (!start) m_mode <= 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string tg;
            tg = (m_mode == 0) ? "R4" : (m_mode == 1) ? "R2" : "R3";
            chk({tg, " done"}, int'(done), (m_mode == 2) ? 1 : 0);
            chk({tg, " q"}, int'(q_out), m_q);
            chk({tg, " r"}, int'(r_out), m_r);
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    // run one division; returns edges counted from start sample to done
    task automatic divide(input int a, input int b, input int hold, input bit perturb);
        int n;
        int exp_q, exp_r;
        @(negedge clk);
        a_in = W'(a); b_in = W'(b); start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (perturb && n == 3) begin a_in = W'(9); b_in = W'(9); end
        end while (!done && n < 1000);
        exp_q = (b == 0) ? MASK : a / b;
        exp_r = (b == 0) ? a : a % b;
        if (b == 0) chk("R7 quotient", int'(q_out), exp_q);
        else        chk(perturb ? "R9 quotient" : "R3 quotient", int'(q_out), exp_q);
        chk((b == 0) ? "R7 remainder" : (perturb ? "R9 remainder" : "R3 remainder"),
            int'(r_out), exp_r);
        chk((b == 0) ? "R7 latency" : "R5 latency", n, (b == 0) ? 1 : exp_q + 2);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R6 done held", int'(done), 1);
            chk("R6 q held", int'(q_out), exp_q);
        end
        start = 1'b0;
        @(negedge clk);
        chk("R6 release", int'(done), 0);
        a_in = W'(a ^ 8'h5A);
        repeat (2) @(negedge clk);
        chk("R4 idle q", int'(q_out), exp_q);
        chk("R4 idle r", int'(r_out), exp_r);
        chk("R4 idle done", int'(done), 0);
    endtask

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        chk("R8 reset q", int'(q_out), 0);
        chk("R8 reset r", int'(r_out), 0);
        chk("R8 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after release", int'(done), 0);

        divide(200, 7, 0, 0);     // R1 R2 R3
        divide(7, 200, 0, 0);     // single borrow cycle
        divide(12, 12, 0, 0);     // equal operands
        divide(255, 1, 0, 0);     // longest loop
        divide(0, 5, 0, 0);       // zero dividend
        divide(100, 0, 3, 0);     // R7 zero divisor
        divide(200, 3, 0, 1);     // R9 operands change mid-loop
        divide(77, 10, 4, 0);     // R6 hold start in done

        seed = 13;
        for (int k = 0; k < 20; k++) begin
            int a, b;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            a = (seed >> 8) & MASK;
            b = ((seed >> 17) & 31) + (k % 4 == 3 ? 0 : 1);
            divide(a, b, k % 3, 0);
        end
        finish_run();
    end

endmodule